// File: doc/BRIEF.md
# Timer-Shared Port Pin Multiplexer

This block is an 8-bit bidirectional port whose pins are lent to timer functions. A direction register sets each pin as input or output, and a port data register holds the output levels. Pin 3 is shared with a 16-bit capture/compare register. A control bit picks the pin's role. In compare role, a match between the shared register and the free-running counter toggles pin 3. In capture role, every level change on pin 3 latches the counter into the shared register and sends a one-cycle strobe to the timer.

The pin 3 edge detector watches the level actually present on the pin. When pin 3 is an output, that level is the latched output value, so a software write to the port can trigger a capture of its own. Pin 7 always feeds a pulse-accumulator tap, whatever its direction. Pin 7 can also be toggled by a compare-match input from the timer. The timer counter and the pulse accumulator themselves lie outside this block.

Top module: `tport_mux`

## Requirements
- R1: The register bus has these addresses: 0 is the port data register, 1 is the direction register, 2 is control (bit 0 selects the pin 3 capture role, bit 1 enables pin 7 compare toggling), 3 is the low byte of the shared register and 4 is its high byte. Addresses 5 to 7 read as zero. The output-enable vector equals the direction register, where a 1 means output. Direction, data and control reset to zero.
- R2: A read of address 0 returns, for each bit, the latched output value where the direction bit is 1 and the pin input level where it is 0.
- R3: After reset, the control register reads 0 and the shared register reads 0xFFFF, so pin 3 is in compare role. In compare role with direction bit 3 set, each cycle in which the counter input equals the shared register toggles the pin 3 output latch.
- R4: A counter match changes nothing on pin 3 when direction bit 3 is clear or when the capture role is selected.
- R5: In capture role with pin 3 an input, each rising or falling edge on pin 3 copies the counter value sampled on that clock edge into the shared register. It also raises the capture strobe for exactly the following cycle. In compare role the strobe stays low.
- R6: In capture role with pin 3 an output, a port data write that changes bit 3 causes a capture one cycle after the write.
- R7: Bus writes to the shared register are ignored in capture role and accepted in compare role.
- R8: The pulse-accumulator tap follows the level on pin 7: the pin input when direction bit 7 is 0, the output latch when it is 1.
- R9: A compare-match pulse for pin 7 toggles the pin 7 output latch only when control bit 1 and direction bit 7 are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| pin_i | input | 8 | Pin input levels |
| pin_o | output | 8 | Pin output levels |
| pin_oe_o | output | 8 | Pin output enables |
| cnt_i | input | 16 | Free-running timer counter |
| cmp7_i | input | 1 | Compare-match pulse for pin 7 |
| cap_stb_o | output | 1 | Capture strobe to the timer |
| pa_o | output | 1 | Pulse-accumulator tap from pin 7 |

## Verification
The assertions are checked on every cycle. They check that a capture strobe always comes with the counter value of the previous cycle held in the shared register, and that no strobe appears in compare role. They also check that the shared register holds still under writes in capture role, that pin 3 stays put while it is an input and the port is not written, and that a direction read matches the output enables. Only the bench scenarios can show which stimuli cause these effects: the read mix over all direction patterns, toggling on a single-cycle match, captures on both edge polarities, the capture set off by a port write, and the pin 7 gating.

// File: rtl/tport_pkg.sv
package tport_pkg;
  typedef enum logic [2:0] {
    A_DATA = 3'd0,
    A_DIR  = 3'd1,
    A_CTL  = 3'd2,
    A_CCL  = 3'd3,
    A_CCH  = 3'd4
  } addr_e;

  localparam int CTL_W   = 2;
  localparam int CTL_CAP = 0;
  localparam int CTL_OC7 = 1;
  localparam int SHR_PIN = 3;
  localparam int PA_PIN  = 7;
endpackage

// File: rtl/tport_regs.sv
module tport_regs
  import tport_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [DW-1:0]    tgl_i,
  output logic [DW-1:0]    dir_o,
  output logic [DW-1:0]    dat_o,
  output logic [CTL_W-1:0] ctl_o
);
  logic wr_dat, wr_dir, wr_ctl;

  assign wr_dat = we_i && (addr_i == A_DATA);
  assign wr_dir = we_i && (addr_i == A_DIR);
  assign wr_ctl = we_i && (addr_i == A_CTL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o <= '0;
      dat_o <= '0;
      ctl_o <= '0;
    end else begin
      if (wr_dir) dir_o <= wdata_i;
      if (wr_ctl) ctl_o <= wdata_i[CTL_W-1:0];
      // a bus write takes priority over a timer toggle
      if (wr_dat) dat_o <= wdata_i;
      else        dat_o <= dat_o ^ tgl_i;
    end
  end
endmodule

// File: rtl/tport_ccr.sv
module tport_ccr #(
  parameter int DW = 8,
  parameter int CW = 2 * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_sel_i,
  input  logic          sense_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          we_lo_i,
  input  logic          we_hi_i,
  input  logic [DW-1:0] wdata_i,
  output logic [CW-1:0] ccr_o,
  output logic          cap_stb_o,
  output logic          match_o
);
  logic sense_q;
  logic pin_edge;

  assign pin_edge = sense_i ^ sense_q;
  assign match_o  = !cap_sel_i && (cnt_i == ccr_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q   <= 1'b0;
      cap_stb_o <= 1'b0;
      ccr_o     <= '1;
    end else begin
      sense_q   <= sense_i;
      cap_stb_o <= cap_sel_i && pin_edge;
      if (cap_sel_i) begin
        if (pin_edge) ccr_o <= cnt_i;
      end else begin
        if (we_lo_i) ccr_o[DW-1:0]  <= wdata_i;
        if (we_hi_i) ccr_o[CW-1:DW] <= wdata_i;
      end
    end
  end

  // R5
  cap_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_stb_o |-> (ccr_o == $past(cnt_i)));

  // R5
  no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_sel_i |=> !cap_stb_o);

  // R7
  ccr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_sel_i && (sense_i == sense_q)) |=> $stable(ccr_o));
endmodule

// File: rtl/tport_mux.sv
module tport_mux
  import tport_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [2:0]      addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  input  logic [DW-1:0]   pin_i,
  output logic [DW-1:0]   pin_o,
  output logic [DW-1:0]   pin_oe_o,
  input  logic [2*DW-1:0] cnt_i,
  input  logic            cmp7_i,
  output logic            cap_stb_o,
  output logic            pa_o
);
  localparam int CW = 2 * DW;

  logic [DW-1:0]    dir, dat, tgl, pin_lvl;
  logic [CTL_W-1:0] ctl;
  logic [CW-1:0]    ccr;
  logic             match;

  tport_regs #(.DW(DW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .tgl_i   (tgl),
    .dir_o   (dir),
    .dat_o   (dat),
    .ctl_o   (ctl)
  );

  tport_ccr #(.DW(DW), .CW(CW)) u_ccr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cap_sel_i (ctl[CTL_CAP]),
    .sense_i   (pin_lvl[SHR_PIN]),
    .cnt_i     (cnt_i),
    .we_lo_i   (we_i && (addr_i == A_CCL)),
    .we_hi_i   (we_i && (addr_i == A_CCH)),
    .wdata_i   (wdata_i),
    .ccr_o     (ccr),
    .cap_stb_o (cap_stb_o),
    .match_o   (match)
  );

  // per-pin level and timer toggle selection
  for (genvar i = 0; i < DW; i++) begin : g_pin
    assign pin_lvl[i] = dir[i] ? dat[i] : pin_i[i];
    if (i == SHR_PIN) begin : g_oc
      assign tgl[i] = match && dir[i];
    end else if (i == PA_PIN) begin : g_oc7
      assign tgl[i] = cmp7_i && ctl[CTL_OC7] && dir[i];
    end else begin : g_gpio
      assign tgl[i] = 1'b0;
    end
  end

  assign pin_o    = dat;
  assign pin_oe_o = dir;
  assign pa_o     = pin_lvl[PA_PIN];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_DATA:  rdata_o = pin_lvl;
      A_DIR:   rdata_o = dir;
      A_CTL:   rdata_o[CTL_W-1:0] = ctl;
      A_CCL:   rdata_o = ccr[DW-1:0];
      A_CCH:   rdata_o = ccr[CW-1:DW];
      default: rdata_o = '0;
    endcase
  end

  // R1
  dir_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_DIR) |-> (rdata_o == pin_oe_o));

  // R4
  pin3_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pin_oe_o[SHR_PIN] && !(we_i && addr_i == A_DATA)) |=> $stable(pin_o[SHR_PIN]));
endmodule

// File: tb/tport_mux_tb.sv
`timescale 1ns/1ps
module tport_mux_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic [7:0]  pin_i = '0;
  logic [7:0]  pin_o, pin_oe_o;
  logic [15:0] cnt_i = '0;
  logic        cmp7_i = 1'b0;
  logic        cap_stb_o, pa_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  tport_mux u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_i(pin_i), .pin_o(pin_o),
    .pin_oe_o(pin_oe_o), .cnt_i(cnt_i), .cmp7_i(cmp7_i),
    .cap_stb_o(cap_stb_o), .pa_o(pa_o)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    addr_i = a;
    #1;
    v = rdata_o;
  endtask

  task automatic rd16(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(3'd3, lo);
    rd(3'd4, hi);
    v = {hi, lo};
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0]  v;
    logic [15:0] s;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // reset state
    chk("R1 oe reset", {8'h0, pin_oe_o}, 16'h0);
    chk("R1 out reset", {8'h0, pin_o}, 16'h0);
    chk("R5 strobe reset", {15'h0, cap_stb_o}, 16'h0);
    rd(3'd2, v); chk("R3 ctl reset", {8'h0, v}, 16'h0);
    rd16(s);     chk("R3 ccr reset", s, 16'hFFFF);
    rd(3'd5, v); chk("R1 addr5 zero", {8'h0, v}, 16'h0);
    rd(3'd7, v); chk("R1 addr7 zero", {8'h0, v}, 16'h0);

    // R2/R8: sweep every direction pattern in compare role, counter off-match
    for (int d = 0; d < 256; d++) begin
      wr(3'd1, d[7:0]);
      for (int k = 0; k < 2; k++) begin
        logic [7:0] pat, pins, exp;
        pat  = d[7:0] ^ 8'h5A ^ (k == 1 ? 8'hFF : 8'h00);
        pins = (k == 1) ? 8'hC3 : 8'h3C;
        pins = pins ^ d[7:0];
        wr(3'd0, pat);
        pin_i = pins;
        exp = (pat & d[7:0]) | (pins & ~d[7:0]);
        rd(3'd0, v);
        chk("R2 port read", {8'h0, v}, {8'h0, exp});
        chk("R1 oe", {8'h0, pin_oe_o}, {8'h0, d[7:0]});
        chk("R8 pa tap", {15'h0, pa_o}, {15'h0, exp[7]});
      end
    end
    pin_i = '0;
    wr(3'd1, 8'h00);

    // R3: compare toggle on pin 3
    wr(3'd2, 8'h00);
    wr(3'd1, 8'h08);
    wr(3'd0, 8'h00);
    wr(3'd3, 8'h10);
    wr(3'd4, 8'h00);
    rd16(s); chk("R7 ccr write compare role", s, 16'h0010);
    cnt_i = 16'h0010;
    @(negedge clk_i); cnt_i = 16'h0011;
    chk("R3 toggle to 1", {15'h0, pin_o[3]}, 16'h1);
    cnt_i = 16'h0010;
    @(negedge clk_i); cnt_i = 16'h0011;
    chk("R3 toggle to 0", {15'h0, pin_o[3]}, 16'h0);
    cnt_i = 16'h0010;
    @(negedge clk_i); cnt_i = 16'h0011;
    chk("R3 toggle to 1 again", {15'h0, pin_o[3]}, 16'h1);

    // R4: no toggle when pin 3 is an input
    wr(3'd1, 8'h00);
    cnt_i = 16'h0010;
    @(negedge clk_i); cnt_i = 16'h0011;
    chk("R4 no toggle dir0", {15'h0, pin_o[3]}, 16'h1);

    // R4: no toggle in capture role
    wr(3'd1, 8'h08);
    wr(3'd2, 8'h01);
    @(negedge clk_i);
    chk("R5 no strobe on role switch", {15'h0, cap_stb_o}, 16'h0);
    cnt_i = 16'h0010;
    @(negedge clk_i); cnt_i = 16'h0011;
    chk("R4 no toggle cap role", {15'h0, pin_o[3]}, 16'h1);

    // R6: port write edge on output pin 3 triggers capture
    cnt_i = 16'hBEEF;
    wr(3'd0, 8'h00);
    chk("R6 no strobe yet", {15'h0, cap_stb_o}, 16'h0);
    @(negedge clk_i);
    chk("R6 strobe after write", {15'h0, cap_stb_o}, 16'h1);
    rd16(s); chk("R6 captured value", s, 16'hBEEF);
    @(negedge clk_i);
    chk("R6 strobe one cycle", {15'h0, cap_stb_o}, 16'h0);

    // R7: shared register writes ignored in capture role
    cnt_i = 16'h0000;
    wr(3'd3, 8'h12);
    wr(3'd4, 8'h34);
    rd16(s); chk("R7 ccr write ignored", s, 16'hBEEF);

    // R5: input edges on pin 3, both polarities
    wr(3'd1, 8'h00);
    @(negedge clk_i);
    for (int i = 0; i < 8; i++) begin
      logic [15:0] c;
      c = 16'h1357 * (i + 1);
      cnt_i = c;
      pin_i[3] = ~pin_i[3];
      @(negedge clk_i);
      chk("R5 strobe on edge", {15'h0, cap_stb_o}, 16'h1);
      rd16(s); chk("R5 captured count", s, c);
      cnt_i = c + 16'd5;
      @(negedge clk_i);
      chk("R5 strobe single cycle", {15'h0, cap_stb_o}, 16'h0);
      rd16(s); chk("R5 value held", s, c);
    end

    // R7: writes accepted again in compare role
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h12);
    wr(3'd4, 8'h34);
    rd16(s); chk("R7 ccr write accepted", s, 16'h3412);
    pin_i[3] = ~pin_i[3];
    @(negedge clk_i); @(negedge clk_i);
    chk("R5 no strobe compare role", {15'h0, cap_stb_o}, 16'h0);

    // R9: pin 7 compare toggle gating
    wr(3'd2, 8'h02);
    wr(3'd1, 8'h80);
    wr(3'd0, 8'h00);
    cmp7_i = 1'b1;
    @(negedge clk_i); cmp7_i = 1'b0;
    chk("R9 pin7 toggled", {15'h0, pin_o[7]}, 16'h1);
    chk("R8 pa follows output", {15'h0, pa_o}, 16'h1);
    wr(3'd2, 8'h00);
    cmp7_i = 1'b1;
    @(negedge clk_i); cmp7_i = 1'b0;
    chk("R9 no toggle oc7 off", {15'h0, pin_o[7]}, 16'h1);
    wr(3'd2, 8'h02);
    wr(3'd1, 8'h00);
    pin_i[7] = 1'b0;
    cmp7_i = 1'b1;
    @(negedge clk_i); cmp7_i = 1'b0;
    chk("R9 no toggle dir7 in", {15'h0, pin_o[7]}, 16'h1);
    #1;
    chk("R8 pa follows input", {15'h0, pa_o}, 16'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule